// File: doc/BRIEF.md
# Two-Stage Top-Two Momentum Selector

This block takes the track candidates of one trigger sector, one candidate per cluster slot, every event. A candidate has a valid bit, a momentum level code, a charge bit and a sub-position within its cluster. The block reports the two tracks with the highest momentum levels in the sector, packed into one 32-bit word for the central trigger interface. It accepts a new event on every clock and produces each result a fixed number of cycles later.

Selection runs in two registered stages. In the first stage, one pre-selector per momentum level takes the candidates of its own level and keeps at most two of them, the ones in the lowest-numbered clusters. In the second stage, a final selector scans the twelve survivors from the highest level down and takes the first two. A flag marks sectors that held more than two usable candidates, so that some tracks were dropped.

Top module: `mps_top`

## Requirements
- R1: When one level has more than two candidates, only the two in the lowest-numbered clusters of that level can be reported.
- R2: Track A (the first track) always has a level code at least as high as track B; a candidate of a higher level is never dropped while a lower-level one is reported.
- R3: Between two reported tracks of the same level, track A is the one in the lower-numbered cluster.
- R4: The word holds track A in bits [10:0] and track B in bits [21:11]. Each track field has valid at bit 0, level code at bits 3:1, charge at bit 4, cluster index at bits 7:5 and sub-position at bits 10:8. The overflow flag is at bit 22, and bits [31:23] are zero.
- R5: When fewer than two usable candidates exist, each missing track field is all zero (valid bit clear).
- R6: The overflow flag is set exactly when more than two usable candidates existed in the event.
- R7: Level codes 6 and 7 are not valid levels; such candidates are neither reported nor counted toward the overflow flag.
- R8: The result of an event presented with in_strb high appears on out_word two clock edges later, with out_strb high in that same cycle; events may arrive on consecutive clocks.
- R9: After a cycle with in_strb low, out_strb is low two edges later and out_word keeps the result of the latest strobed event.
- R10: During and after reset, before any strobed event, out_word is zero and out_strb is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_strb | input | 1 | Event present this cycle |
| in_vld | input | 8 | Candidate present, one bit per cluster |
| in_lvl | input | 24 | Level code per cluster, 3 bits each, cluster i at [3i+2:3i] |
| in_chg | input | 8 | Charge bit per cluster |
| in_sub | input | 24 | Sub-position per cluster, 3 bits each |
| out_strb | output | 1 | Result word valid this cycle |
| out_word | output | 32 | Packed pair of selected tracks and overflow flag |

## Verification
The hardest case to reach from the ports is the per-level cut: three or more candidates must share one level while no higher level is populated, so that both reported tracks come from that level and the third is dropped. Purely random stimulus spreads candidates over eight level codes and seldom produces this. The bench therefore adds directed events that crowd one level, and its random phase draws levels from a narrow band in every other event to make these collisions common. Gaps in the strobe are mixed in throughout so that the hold behaviour is checked between back-to-back events.

// File: rtl/mps_pkg.sv
package mps_pkg;
  localparam int N_CLUST  = 8;
  localparam int NUM_LVL  = 6;
  localparam int LVL_W    = 3;
  localparam int SUB_W    = 3;
  localparam int CLU_W    = $clog2(N_CLUST);
  localparam int WORD_W   = 32;
  localparam int NSURV    = 2 * NUM_LVL;
  localparam int CNT_W    = $clog2(N_CLUST + 1);

  typedef struct packed {
    logic [SUB_W-1:0] sub;
    logic [CLU_W-1:0] clu;
    logic             chg;
    logic [LVL_W-1:0] lvl;
    logic             vld;
  } trk_t;

  localparam int TRK_W = $bits(trk_t);
  localparam int PAD_W = WORD_W - 2 * TRK_W - 1;
endpackage

// File: rtl/mps_presel.sv
module mps_presel
  import mps_pkg::*;
#(
  parameter int LEVEL = 0
) (
  input  trk_t [N_CLUST-1:0] cand,
  output trk_t [1:0]         keep
);
  always_comb begin
    logic got0;
    logic got1;
    got0 = 1'b0;
    got1 = 1'b0;
    keep = '0;
    for (int i = 0; i < N_CLUST; i++) begin
      if (cand[i].vld && (cand[i].lvl == LVL_W'(LEVEL))) begin
        if (!got0) begin
          keep[0] = cand[i];
          got0    = 1'b1;
        end else if (!got1) begin
          keep[1] = cand[i];
          got1    = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mps_final.sv
module mps_final
  import mps_pkg::*;
(
  input  trk_t [NSURV-1:0] surv,
  output trk_t             first,
  output trk_t             second
);
  always_comb begin
    logic got0;
    logic got1;
    got0   = 1'b0;
    got1   = 1'b0;
    first  = '0;
    second = '0;
    for (int j = 0; j < NSURV; j++) begin
      if (surv[j].vld) begin
        if (!got0) begin
          first = surv[j];
          got0  = 1'b1;
        end else if (!got1) begin
          second = surv[j];
          got1   = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mps_top.sv
module mps_top
  import mps_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_strb,
  input  logic [N_CLUST-1:0]       in_vld,
  input  logic [N_CLUST*LVL_W-1:0] in_lvl,
  input  logic [N_CLUST-1:0]       in_chg,
  input  logic [N_CLUST*SUB_W-1:0] in_sub,
  output logic                     out_strb,
  output logic [WORD_W-1:0]        out_word
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // candidate formation; out-of-range level codes are dropped here
  trk_t [N_CLUST-1:0] cand;
  logic [CNT_W-1:0]   usable_cnt;
  always_comb begin
    usable_cnt = '0;
    for (int i = 0; i < N_CLUST; i++) begin
      cand[i].sub = in_sub[i*SUB_W +: SUB_W];
      cand[i].clu = CLU_W'(i);
      cand[i].chg = in_chg[i];
      cand[i].lvl = in_lvl[i*LVL_W +: LVL_W];
      cand[i].vld = in_vld[i] && (int'(in_lvl[i*LVL_W +: LVL_W]) < NUM_LVL);
      usable_cnt  = usable_cnt + CNT_W'(cand[i].vld);
    end
  end

  // stage 1: one pre-selector per level, survivors ordered high level first
  trk_t [NSURV-1:0] surv_d;
  genvar gl;
  generate
    for (gl = 0; gl < NUM_LVL; gl++) begin : g_lvl
      trk_t [1:0] keep;
      mps_presel #(.LEVEL(gl)) u_pre (
        .cand (cand),
        .keep (keep)
      );
      assign surv_d[2*(NUM_LVL-1-gl)]     = keep[0];
      assign surv_d[2*(NUM_LVL-1-gl) + 1] = keep[1];
    end
  endgenerate

  trk_t [NSURV-1:0] surv_q;
  logic             ovf_d, ovf_q, stb1_q;
  assign ovf_d = (usable_cnt > CNT_W'(2));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      surv_q <= '0;
      ovf_q  <= 1'b0;
      stb1_q <= 1'b0;
    end else begin
      stb1_q <= in_strb;
      if (in_strb) begin
        surv_q <= surv_d;
        ovf_q  <= ovf_d;
      end
    end
  end

  // stage 1 survivors: within a level the first slot is the lower cluster
  generate
    for (gl = 0; gl < NUM_LVL; gl++) begin : g_chk
      a_r3_slot_order: assert property (@(posedge clk) disable iff (!rst_sync_n)
        surv_q[2*gl+1].vld |-> (surv_q[2*gl].vld && (surv_q[2*gl].clu < surv_q[2*gl+1].clu)));
    end
  endgenerate

  // stage 2: final selection over the survivors and packing
  trk_t             fin_a, fin_b;
  logic [WORD_W-1:0] word_d, word_q;
  logic              stb2_q;

  mps_final u_fin (
    .surv   (surv_q),
    .first  (fin_a),
    .second (fin_b)
  );

  assign word_d = {{PAD_W{1'b0}}, ovf_q, fin_b, fin_a};

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      word_q <= '0;
      stb2_q <= 1'b0;
    end else begin
      stb2_q <= stb1_q;
      if (stb1_q) begin
        word_q <= word_d;
      end
    end
  end

  assign out_word = word_q;
  assign out_strb = stb2_q;

  trk_t wa, wb;
  assign wa = out_word[TRK_W-1:0];
  assign wb = out_word[2*TRK_W-1:TRK_W];

  a_r2_rank: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb.vld |-> (wa.vld && (wa.lvl >= wb.lvl)));

  a_r3_same_level_order: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wb.vld && (wa.lvl == wb.lvl)) |-> (wa.clu < wb.clu));

  a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wb.vld |-> (wb == '0));

  a_r6_flag_full: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_word[2*TRK_W] |-> (wa.vld && wb.vld));

  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_word[WORD_W-1:2*TRK_W+1] == '0);

  a_r7_level_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wa.vld || (int'(wa.lvl) < NUM_LVL)) && (!wb.vld || (int'(wb.lvl) < NUM_LVL)));

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_strb |-> ##2 out_strb);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_strb |-> ##2 (!out_strb && $stable(out_word)));
endmodule

// File: tb/sim_mps_top.sv
module sim_mps_top;
  localparam int NC = 8;

  logic        clk, rst_n, in_strb, out_strb;
  logic [7:0]  in_vld, in_chg;
  logic [23:0] in_lvl, in_sub;
  logic [31:0] out_word;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  mps_top u0 (
    .clk(clk), .rst_n(rst_n), .in_strb(in_strb), .in_vld(in_vld),
    .in_lvl(in_lvl), .in_chg(in_chg), .in_sub(in_sub),
    .out_strb(out_strb), .out_word(out_word)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // expected pipeline history, filled when a vector is driven
  logic [31:0] h1_word, h2_word, hold_word;
  logic        h1_strb, h2_strb;
  string       h1_tag, h2_tag;

  function automatic logic [31:0] expect_word(logic [7:0] v, logic [23:0] l,
                                              logic [7:0] c, logic [23:0] s);
    logic [10:0] ta, tb;
    int n, total;
    ta = '0; tb = '0; n = 0; total = 0;
    for (int i = 0; i < NC; i++)
      if (v[i] && l[3*i +: 3] < 3'd6) total++;
    for (int lv = 5; lv >= 0; lv--)
      for (int i = 0; i < NC; i++)
        if (v[i] && int'(l[3*i +: 3]) == lv) begin
          if (n == 0) ta = {s[3*i +: 3], 3'(i), c[i], 3'(lv), 1'b1};
          else if (n == 1) tb = {s[3*i +: 3], 3'(i), c[i], 3'(lv), 1'b1};
          n++;
        end
    return {9'd0, (total > 2), tb, ta};
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic strb, logic [7:0] v, logic [23:0] l,
                      logic [7:0] c, logic [23:0] s, string tag);
    logic [31:0] exp;
    @(negedge clk);
    // outputs now reflect the vector driven two negedges ago
    exp = h2_strb ? h2_word : hold_word;
    if (h2_strb) hold_word = h2_word;
    cmp({h2_tag, " R8"}, "out_strb", 32'(out_strb), 32'(h2_strb));
    cmp({h2_tag, " R2"}, "track A", 32'(out_word[10:0]), 32'(exp[10:0]));
    cmp({h2_tag, " R3"}, "track B", 32'(out_word[21:11]), 32'(exp[21:11]));
    cmp({h2_tag, " R6"}, "overflow", 32'(out_word[22]), 32'(exp[22]));
    cmp({h2_tag, " R4"}, "pad", 32'(out_word[31:23]), 32'd0);
    if (!h2_strb) cmp({h2_tag, " R9"}, "held word", out_word, hold_word);
    vectors++;
    h2_word = h1_word; h2_strb = h1_strb; h2_tag = h1_tag;
    h1_word = expect_word(v, l, c, s); h1_strb = strb; h1_tag = tag;
    in_strb = strb; in_vld = v; in_lvl = l; in_chg = c; in_sub = s;
  endtask

  function automatic logic [23:0] put3(logic [23:0] f, int idx, int val);
    logic [23:0] r;
    r = f;
    r[3*idx +: 3] = 3'(val);
    return r;
  endfunction

  initial begin
    logic [23:0] l, s;
    rst_n = 1'b0; in_strb = 0; in_vld = 0; in_lvl = 0; in_chg = 0; in_sub = 0;
    h1_word = 0; h2_word = 0; hold_word = 0; h1_strb = 0; h2_strb = 0;
    h1_tag = "R10"; h2_tag = "R10";
    repeat (3) @(negedge clk);
    // R10: reset state
    cmp("R10", "reset word", out_word, 32'd0);
    cmp("R10", "reset strobe", 32'(out_strb), 32'd0);
    vectors++;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R10", "idle word", out_word, 32'd0);
    cmp("R10", "idle strobe", 32'(out_strb), 32'd0);
    vectors++;

    // R1: three level-5 candidates, clusters 1,4,6
    l = 0; l = put3(l, 1, 5); l = put3(l, 4, 5); l = put3(l, 6, 5);
    step(1, 8'b0101_0010, l, 8'h12, 24'h123456, "R1");
    // R2: level 0 at cluster 0, level 3 at cluster 7
    l = 0; l = put3(l, 0, 0); l = put3(l, 7, 3);
    step(1, 8'b1000_0001, l, 8'h80, 24'hfac688, "R2");
    // R3: two level-2 candidates at clusters 5 and 2
    l = 0; l = put3(l, 5, 2); l = put3(l, 2, 2);
    step(1, 8'b0010_0100, l, 8'h04, 24'h5a5a5a, "R3");
    // R5: single candidate, then none
    l = put3(24'd0, 3, 4);
    step(1, 8'b0000_1000, l, 8'h08, 24'hffffff, "R5");
    step(1, 8'h00, 24'hffffff, 8'hff, 24'hffffff, "R5");
    // R7: out-of-range codes everywhere except one level-1 candidate
    l = 24'hffffff; l = put3(l, 2, 6); l = put3(l, 5, 1);
    step(1, 8'hff, l, 8'h55, 24'h0f0f0f, "R7");
    // R6: exactly three usable candidates across levels
    l = 24'hffffff; l = put3(l, 0, 0); l = put3(l, 3, 2); l = put3(l, 6, 4);
    step(1, 8'hff, l, 8'hff, 24'h000000, "R6");
    // R9: strobe gaps with busy inputs
    step(0, 8'hff, 24'h000000, 8'hff, 24'h111111, "R9");
    step(0, 8'hff, 24'h249249, 8'h00, 24'h222222, "R9");
    step(1, 8'h00, 24'h0, 8'h0, 24'h0, "R8");
    step(0, 8'hff, 24'h6db6db, 8'hff, 24'h777777, "R9");

    // random sweep; odd events crowd a narrow level band
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] v;
      v = 8'($urandom);
      l = 24'($urandom);
      if (k % 2 == 1)
        for (int i = 0; i < NC; i++) l = put3(l, i, 3 + int'($urandom_range(0, 1)));
      s = 24'($urandom);
      step(($urandom_range(0, 4) != 0), v, l, 8'($urandom), s, "R1");
    end
    step(0, 8'h0, 24'h0, 8'h0, 24'h0, "R9");
    step(0, 8'h0, 24'h0, 8'h0, 24'h0, "R9");
    step(0, 8'h0, 24'h0, 8'h0, 24'h0, "R9");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule